// File: doc/BRIEF.md
# Dual-Reader Circular Buffer

This block is a single-clock ring of storage with one producer and two independent consumers. Every element the producer writes has to be taken by both consumers before its slot can be written again. Each consumer walks the ring at its own pace through its own pointer. The producer sees the ring as full once it has caught up with whichever consumer lags furthest behind.

Each consumer has its own empty flag, so the ring can be empty for one consumer and still hold data for the other. It can also be full for the producer while one consumer has nothing left to read. The block does not track the lagging consumer by subtracting pointers. It keeps a flag per consumer that says "this consumer may be the one furthest behind", together with a saved copy of the lagging pointer. A request that cannot be served is dropped and flagged on an error output one clock later.

Top module: `dual_tap_ring`

## Requirements
- R1: After reset both empty flags are 1, full is 0, all three error outputs are 0 and both read data outputs are 0.
- R2: An accepted read returns, on its data output in the clock after the strobe, the oldest element that this consumer has not yet taken, in write order. The data output holds its value when no read is accepted.
- R3: The pointers wrap from the last slot back to slot 0, so data keeps its order across any number of passes through the DEPTH slots.
- R4: full becomes 1 when an accepted write brings the write pointer level with the lagging consumer. full returns to 0 only when that lagging consumer advances. A read by the consumer that is further ahead leaves full unchanged.
- R5: A consumer's empty flag becomes 1 when its read brings its pointer level with the write pointer. Any accepted write clears both empty flags.
- R6: full can be 1 while one consumer's empty flag is also 1, and the other consumer can still read in that state.
- R7: A write attempted while full is 1 is dropped. wr_err is 1 in the next clock, and neither the stored data nor the write position changes.
- R8: A read attempted while that consumer's empty flag is 1 is dropped. Its error output is 1 in the next clock, and its data output and read position do not change.
- R9: When a write and one or both reads are accepted in the same clock, the flags and data that result are those of performing the reads first and then the write. A write is accepted when full is 0 and a read is accepted when its empty flag is 0, both judged at the start of that clock.
- R10: When both consumers sit at the same position while the ring is full, one of them reading leaves full at 1, because the other consumer still lags a full DEPTH behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_data | input | WIDTH | Data to store |
| full | output | 1 | Ring is full for the producer |
| wr_err | output | 1 | A write was dropped in the previous clock |
| rd0_strobe | input | 1 | Read request, consumer 0 |
| rd0_data | output | WIDTH | Registered read data, consumer 0 |
| rd0_empty | output | 1 | Nothing left for consumer 0 |
| rd0_err | output | 1 | A read by consumer 0 was dropped in the previous clock |
| rd1_strobe | input | 1 | Read request, consumer 1 |
| rd1_data | output | WIDTH | Registered read data, consumer 1 |
| rd1_empty | output | 1 | Nothing left for consumer 1 |
| rd1_err | output | 1 | A read by consumer 1 was dropped in the previous clock |

## Verification
A wrong "may be lagging" flag or a stale copy of the lagging pointer does not show at once. It shows as a full flag that clears on the wrong consumer's read, or that never sets, and this appears a few operations later when the producer tries to write past the lag. The directed scenarios therefore drive the ring to full and then read from the leading consumer, from the lagging consumer and from a tied pair. An off-by-one pointer shows at the data outputs in the very next clock, and an empty flag that is wrong for one consumer shows as a spurious or missing error pulse, also in the next clock.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Number of address bits needed to index a ring of the given depth.
  function automatic int unsigned ring_addr_bits(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // Number of consumers the ring serves.
  localparam int unsigned TAP_COUNT = 2;

endpackage

// File: rtl/ring_store.sv
module ring_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned TAPS  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic [TAPS-1:0]            re,
  input  logic [TAPS-1:0][AW-1:0]    raddr,
  output logic [TAPS-1:0][WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  // One registered output port per consumer; it only moves on an accepted read.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[t] <= '0;
      else if (re[t]) rdata[t] <= slots[raddr[t]];
    end

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !re[t] |=> $stable(rdata[t]));
  end

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        rd_req,
  output logic              wr_acc,
  output logic [1:0]        rd_acc,
  output logic [AW-1:0]     wptr,
  output logic [1:0][AW-1:0] rptr,
  output logic              full,
  output logic [1:0]        empty,
  output logic              wr_err,
  output logic [1:0]        rd_err
);

  localparam logic [AW-1:0] TOP_SLOT = AW'(DEPTH - 1);

  // Advance a pointer by one slot, wrapping at the top of the ring.
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == TOP_SLOT) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0]      lag_ptr;   // copy of the lagging consumer's pointer
  logic [1:0]         lagging;   // per-consumer "may be furthest behind" flags

  logic [AW-1:0]      n_wptr, n_lag;
  logic [1:0][AW-1:0] n_rptr;
  logic [1:0]         n_empty, n_lagging;
  logic               n_full;

  assign wr_acc = wr_valid & ~full;
  assign rd_acc = rd_req & ~empty;

  // Reads are applied first (consumer 0 then consumer 1), then the write.
  always_comb begin
    n_wptr    = wptr;
    n_rptr    = rptr;
    n_lag     = lag_ptr;
    n_full    = full;
    n_empty   = empty;
    n_lagging = lagging;
    for (int t = 0; t < 2; t++) begin
      if (rd_acc[t]) begin
        n_rptr[t] = step(rptr[t]);
        if (n_rptr[t] == wptr) n_empty[t] = 1'b1;
        if (n_lagging[1-t]) begin
          n_lagging[t] = 1'b0;
        end else begin
          n_lag  = n_rptr[t];
          n_full = 1'b0;
          if (n_rptr[t] == n_rptr[1-t]) n_lagging[1-t] = 1'b1;
        end
      end
    end
    if (wr_acc) begin
      n_wptr  = step(wptr);
      n_empty = 2'b00;
      if (n_wptr == n_lag) n_full = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      lag_ptr <= '0;
      full    <= 1'b0;
      empty   <= 2'b11;
      lagging <= 2'b11;
      wr_err  <= 1'b0;
      rd_err  <= 2'b00;
    end else begin
      wptr    <= n_wptr;
      rptr    <= n_rptr;
      lag_ptr <= n_lag;
      full    <= n_full;
      empty   <= n_empty;
      lagging <= n_lagging;
      wr_err  <= wr_valid & full;
      rd_err  <= rd_req & empty;
    end
  end

  // Some consumer is always marked as possibly lagging, and the saved copy matches it.
  assert_lag_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lagging != 2'b00);
  assert_lag_copy0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lagging[0] |-> (lag_ptr == rptr[0]));
  assert_lag_copy1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lagging[1] |-> (lag_ptr == rptr[1]));
  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full && (rd_acc == 2'b00) |=> full);
  assert_write_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (empty == 2'b00));
  assert_full_has_reader_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (empty != 2'b11));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(wptr));
  assert_no_underflow0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[0] && empty[0] |=> rd_err[0] && $stable(rptr[0]));
  assert_no_underflow1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[1] && empty[1] |=> rd_err[1] && $stable(rptr[1]));

endmodule

// File: rtl/dual_tap_ring.sv
module dual_tap_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             wr_err,
  input  logic             rd0_strobe,
  output logic [WIDTH-1:0] rd0_data,
  output logic             rd0_empty,
  output logic             rd0_err,
  input  logic             rd1_strobe,
  output logic [WIDTH-1:0] rd1_data,
  output logic             rd1_empty,
  output logic             rd1_err
);
  import ring_pkg::*;

  localparam int unsigned AW   = ring_addr_bits(DEPTH);
  localparam int unsigned TAPS = TAP_COUNT;

  // Internal events brought out as named wires.
  logic                       wr_acc;
  logic [TAPS-1:0]            rd_acc;
  logic [AW-1:0]              wptr;
  logic [TAPS-1:0][AW-1:0]    rptr;
  logic [TAPS-1:0]            empty;
  logic [TAPS-1:0]            rd_err;
  logic [TAPS-1:0][WIDTH-1:0] rdata;

  ring_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .rd_req   ({rd1_strobe, rd0_strobe}),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .wptr     (wptr),
    .rptr     (rptr),
    .full     (full),
    .empty    (empty),
    .wr_err   (wr_err),
    .rd_err   (rd_err)
  );

  ring_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .TAPS(TAPS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_acc),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_acc),
    .raddr (rptr),
    .rdata (rdata)
  );

  assign rd0_data  = rdata[0];
  assign rd1_data  = rdata[1];
  assign rd0_empty = empty[0];
  assign rd1_empty = empty[1];
  assign rd0_err   = rd_err[0];
  assign rd1_err   = rd_err[1];

  assert_wr_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && full |=> wr_err);
  assert_rd0_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_strobe && rd0_empty |=> $stable(rd0_data));
  assert_rd1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_strobe && rd1_empty |=> $stable(rd1_data));

endmodule

// File: tb/dual_tap_ring_test.sv
`timescale 1ns/100ps
module dual_tap_ring_test;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd0_strobe = 1'b0, rd1_strobe = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic full, wr_err, rd0_empty, rd0_err, rd1_empty, rd1_err;
  logic [WIDTH-1:0] rd0_data, rd1_data;

  always #2.5 clk = ~clk;

  dual_tap_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .full(full), .wr_err(wr_err),
    .rd0_strobe(rd0_strobe), .rd0_data(rd0_data), .rd0_empty(rd0_empty), .rd0_err(rd0_err),
    .rd1_strobe(rd1_strobe), .rd1_data(rd1_data), .rd1_empty(rd1_empty), .rd1_err(rd1_err)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // Reference model: counts of writes and reads per consumer.
  logic [WIDTH-1:0] ref_mem [DEPTH];
  int wr_total = 0, rd_total0 = 0, rd_total1 = 0;
  logic [WIDTH-1:0] exp_d0 = '0, exp_d1 = '0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lag_count();
    int r = (rd_total0 < rd_total1) ? rd_total0 : rd_total1;
    return wr_total - r;
  endfunction

  // One clock of stimulus; called at a falling edge, returns at the next one.
  task automatic op(input logic w, input logic [WIDTH-1:0] d,
                    input logic r0, input logic r1, input string req);
    bit wa, ra0, ra1;
    wa  = w  && (lag_count() != DEPTH);
    ra0 = r0 && (wr_total - rd_total0 != 0);
    ra1 = r1 && (wr_total - rd_total1 != 0);
    wr_valid = w; wr_data = d; rd0_strobe = r0; rd1_strobe = r1;
    if (ra0) begin exp_d0 = ref_mem[rd_total0 % DEPTH]; rd_total0++; end
    if (ra1) begin exp_d1 = ref_mem[rd_total1 % DEPTH]; rd_total1++; end
    if (wa)  begin ref_mem[wr_total % DEPTH] = d; wr_total++; end
    @(posedge clk); #1;
    chk(req, "rd0_data", int'(rd0_data), int'(exp_d0));
    chk(req, "rd1_data", int'(rd1_data), int'(exp_d1));
    chk(req, "wr_err", int'(wr_err), int'(w && !wa));
    chk(req, "rd0_err", int'(rd0_err), int'(r0 && !ra0));
    chk(req, "rd1_err", int'(rd1_err), int'(r1 && !ra1));
    chk(req, "full", int'(full), int'(lag_count() == DEPTH));
    chk(req, "rd0_empty", int'(rd0_empty), int'(wr_total == rd_total0));
    chk(req, "rd1_empty", int'(rd1_empty), int'(wr_total == rd_total1));
    @(negedge clk);
    wr_valid = 1'b0; rd0_strobe = 1'b0; rd1_strobe = 1'b0;
  endtask

  task automatic test_reset_R1();
    chk("R1", "full", int'(full), 0);
    chk("R1", "rd0_empty", int'(rd0_empty), 1);
    chk("R1", "rd1_empty", int'(rd1_empty), 1);
    chk("R1", "errors", int'({wr_err, rd0_err, rd1_err}), 0);
    chk("R1", "rd0_data", int'(rd0_data), 0);
    chk("R1", "rd1_data", int'(rd1_data), 0);
  endtask

  task automatic test_order_R2();
    for (int i = 0; i < 3; i++) op(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) op(1'b0, '0, 1'b1, 1'b0, "R2");
    op(1'b0, '0, 1'b0, 1'b0, "R2 hold");
    for (int i = 0; i < 3; i++) op(1'b0, '0, 1'b0, 1'b1, "R5");
  endtask

  task automatic test_empty_R8();
    op(1'b0, '0, 1'b1, 1'b1, "R8");
    op(1'b0, '0, 1'b1, 1'b0, "R8");
  endtask

  task automatic test_full_R4();
    for (int i = 0; i < DEPTH; i++) op(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, "R4 fill");
    op(1'b1, 8'hEE, 1'b0, 1'b0, "R7");            // dropped write
    op(1'b0, '0, 1'b1, 1'b0, "R10");              // tied pair, one reads
    for (int i = 1; i < DEPTH; i++) op(1'b0, '0, 1'b1, 1'b0, "R6");
    op(1'b0, '0, 1'b1, 1'b0, "R6 R8");            // consumer 0 empty while full
    op(1'b0, '0, 1'b0, 1'b1, "R4 clear");         // lagging consumer frees a slot
    op(1'b1, 8'h77, 1'b0, 1'b0, "R3 R4");         // wraps, full again
    op(1'b1, 8'h78, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 3; i++) op(1'b0, '0, 1'b0, 1'b1, "R3");
  endtask

  task automatic test_concurrent_R9();
    op(1'b1, 8'hA1, 1'b1, 1'b1, "R9");
    op(1'b1, 8'hA2, 1'b1, 1'b1, "R9");
    for (int i = 0; i < DEPTH; i++) op(1'b0, '0, 1'b0, 1'b1, "R9 drain");
    for (int i = 0; i < DEPTH; i++) op(1'b0, '0, 1'b1, 1'b0, "R9 drain");
    op(1'b1, 8'hB0, 1'b1, 1'b1, "R9 empty");      // reads rejected, write lands
    op(1'b1, 8'hB1, 1'b1, 1'b0, "R9");
    op(1'b0, '0, 1'b1, 1'b1, "R9");
    op(1'b0, '0, 1'b0, 1'b1, "R9");
  endtask

  task automatic test_wrap_R3();
    for (int k = 0; k < 3 * DEPTH; k++)
      op(1'b1, 8'hC0 + 8'(k), 1'b1, (k % 2) == 0, "R3");
    for (int i = 0; i < 2 * DEPTH; i++) op(1'b0, '0, 1'b1, 1'b1, "R3 drain");
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_R1();
    test_order_R2();
    test_empty_R8();
    test_full_R4();
    test_concurrent_R9();
    test_wrap_R3();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule